// File: doc/BRIEF.md
# Host-triggered recovery listener with KCS-style registers

This peripheral sits on the managed controller and gives the host a minimal path to ask for a debug capture and restart. It holds three registers in the familiar keyboard-controller-style layout: a byte the host writes (input data), a byte local firmware can leave for the host (output data) and a status byte. The host writes bytes through a small bus port and polls status. Local firmware uses a second port to set or clear the software-owned status bits, consume the input byte and, if it wants, load the output byte.

A hardware detector watches every byte that local firmware consumes. When the consumed byte is the recovery code 0x44 and the Ready bit is set, the detector emits a one-cycle recovery request and drops Ready at once, so the host can see from polling that the listener has accepted the request. Recovery needs neither an interrupt towards the host nor any output-data traffic. A level interrupt towards local firmware follows the input-full flag, so firmware can sleep until a byte lands. While the block is held in reset, host status reads return a no-response indication in place of data.

Top module: `kcs_recovery_trigger`

## Requirements
- R1: After reset, the status byte reads 0x00, the local interrupt is low and the recovery request is low.
- R2: A host write with `host_addr`=0 stores the byte in the input data register, sets input-full (status bit 1) and clears command/data (status bit 3); `loc_irq` is high while input-full is set.
- R3: A host write with `host_addr`=1 stores the byte in the input data register, sets input-full and sets command/data (status bit 3).
- R4: A local consume (`loc_idr_rd`) clears input-full at the next clock edge; a host write in the same cycle wins and leaves input-full set with the new byte.
- R5: A local status write changes only bits 7, 6, 5, 4 and 2 (and any bit above 7); bits 3, 1 and 0 keep their hardware values.
- R6: Consuming the byte 0x44 while Ready (status bit 4) is set raises `recover_req` for exactly one cycle, starting at the edge that samples the consume, and clears Ready at that same edge, whether the byte came through `host_addr` 0 or 1.
- R7: Consuming 0x44 with Ready clear, or any other byte with Ready set, raises no request and leaves Ready unchanged; the byte is simply consumed.
- R8: A local output write sets output-full (status bit 0); a host read with `host_addr`=0 returns the output byte and clears output-full at the next edge.
- R9: While `rst_n` is low, a host read drives `host_norsp` high and `host_rdata` to zero; out of reset `host_norsp` stays low and a read with `host_addr`=1 returns status.
- R10: When a recovery fires in the same cycle as a local status write that sets Ready, the recovery wins and Ready ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low local reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = data address, 1 = command/status address |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read data (status or output byte) |
| host_norsp | output | 1 | Host read got no response (block in reset) |
| loc_sw_wr | input | 1 | Local write of software-owned status bits |
| loc_sw_wdata | input | DW | Value for the software-owned status bits |
| loc_idr_rd | input | 1 | Local consume of the input byte |
| loc_idr_data | output | DW | Current input data register |
| loc_odr_wr | input | 1 | Local write of the output byte |
| loc_odr_wdata | input | DW | Output byte value |
| loc_status | output | DW | Current status byte |
| loc_irq | output | 1 | Local interrupt, high while input-full is set |
| recover_req | output | 1 | One-cycle recovery request |

## Verification
The detector is driven with the recovery code and Ready set through both host addresses, with the code while Ready is clear, and with a neighbouring byte (0x45) while Ready is set; only the first pair may fire, which separates a byte compare from a Ready gate and from the command/data flag. Simultaneous host write and consume, and simultaneous recovery and Ready write, tell apart the two priority orders. Software writes of all ones tell whether hardware bits leak through the mask, and host reads held in reset tell the no-response path apart from a zero status.

// File: rtl/kcs_rt_pkg.sv
package kcs_rt_pkg;
   localparam int BIT_OBF = 0;
   localparam int BIT_IBF = 1;
   localparam int BIT_CD  = 3;
   localparam int BIT_RDY = 4;
   localparam logic [7:0] HW_MASK8 = 8'h0B;
   localparam logic [7:0] RECOVER_CODE = 8'h44;
endpackage

// File: rtl/kcs_rt_ibuf.sv
module kcs_rt_ibuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          is_cmd,
   input  logic [DW-1:0] wdata,
   input  logic          consume,
   output logic [DW-1:0] idr,
   output logic          ibf,
   output logic          cd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idr <= '0;
         ibf <= 1'b0;
         cd  <= 1'b0;
      end else if (wr) begin
         idr <= wdata;
         ibf <= 1'b1;
         cd  <= is_cmd;
      end else if (consume) begin
         ibf <= 1'b0;
      end
   end
endmodule

// File: rtl/kcs_rt_obuf.sv
module kcs_rt_obuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] ldata,
   input  logic          drain,
   output logic [DW-1:0] odr,
   output logic          obf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odr <= '0;
         obf <= 1'b0;
      end else if (load) begin
         odr <= ldata;
         obf <= 1'b1;
      end else if (drain) begin
         obf <= 1'b0;
      end
   end
endmodule

// File: rtl/kcs_rt_detect.sv
module kcs_rt_detect #(
   parameter int          DW   = 8,
   parameter logic [7:0]  CODE = 8'h44
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          consume,
   input  logic [DW-1:0] byte_in,
   input  logic          armed,
   output logic          hit,
   output logic          req
);
   localparam logic [DW-1:0] CODE_W = DW'(CODE);

   assign hit = consume && armed && (byte_in == CODE_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= hit;
   end
endmodule

// File: rtl/kcs_recovery_trigger.sv
module kcs_recovery_trigger #(
   parameter int         DW          = 8,
   parameter logic [7:0] CODE        = kcs_rt_pkg::RECOVER_CODE,
   parameter bit         ODR_PRESENT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic          host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_norsp,
   input  logic          loc_sw_wr,
   input  logic [DW-1:0] loc_sw_wdata,
   input  logic          loc_idr_rd,
   output logic [DW-1:0] loc_idr_data,
   input  logic          loc_odr_wr,
   input  logic [DW-1:0] loc_odr_wdata,
   output logic [DW-1:0] loc_status,
   output logic          loc_irq,
   output logic          recover_req
);
   import kcs_rt_pkg::*;

   localparam logic [DW-1:0] HW_MASK = DW'(HW_MASK8);
   localparam logic [DW-1:0] SW_MASK = ~HW_MASK;

   if (DW < 8) begin : g_bad_width
      $error("kcs_recovery_trigger: DW must be at least 8");
   end

   logic [DW-1:0] idr_q, odr_q, sw_q;
   logic          ibf_q, cd_q, obf_q, hit;

   kcs_rt_ibuf #(.DW(DW)) u_ibuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (host_wr),
      .is_cmd  (host_addr),
      .wdata   (host_wdata),
      .consume (loc_idr_rd),
      .idr     (idr_q),
      .ibf     (ibf_q),
      .cd      (cd_q)
   );

   if (ODR_PRESENT) begin : g_odr
      kcs_rt_obuf #(.DW(DW)) u_obuf (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (loc_odr_wr),
         .ldata (loc_odr_wdata),
         .drain (host_rd && !host_addr),
         .odr   (odr_q),
         .obf   (obf_q)
      );
   end else begin : g_no_odr
      assign odr_q = '0;
      assign obf_q = 1'b0;
   end

   kcs_rt_detect #(.DW(DW), .CODE(CODE)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .consume (loc_idr_rd),
      .byte_in (idr_q),
      .armed   (sw_q[BIT_RDY]),
      .hit     (hit),
      .req     (recover_req)
   );

   // software-owned bits; a recovery hit overrides a concurrent Ready write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= '0;
      end else begin
         logic [DW-1:0] nxt;
         nxt = loc_sw_wr ? (loc_sw_wdata & SW_MASK) : sw_q;
         if (hit) nxt[BIT_RDY] = 1'b0;
         sw_q <= nxt;
      end
   end

   always_comb begin
      loc_status          = sw_q & SW_MASK;
      loc_status[BIT_CD]  = cd_q;
      loc_status[BIT_IBF] = ibf_q;
      loc_status[BIT_OBF] = obf_q;
   end

   assign loc_idr_data = idr_q;
   assign loc_irq      = ibf_q;
   assign host_norsp   = host_rd && !rst_n;
   assign host_rdata   = !rst_n ? '0 : (host_addr ? loc_status : odr_q);
endmodule

// File: rtl/kcs_rt_chk.sv
module kcs_rt_chk #(
   parameter int         DW   = 8,
   parameter logic [7:0] CODE = 8'h44
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic          host_addr,
   input logic          loc_idr_rd,
   input logic [DW-1:0] loc_idr_data,
   input logic [DW-1:0] loc_status,
   input logic          loc_irq,
   input logic          recover_req
);
   localparam logic [DW-1:0] CODE_W = DW'(CODE);

   p_wr_sets_ibf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> (loc_status[1] && loc_irq));

   p_cmd_sets_cd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr) |=> loc_status[3]);

   p_consume_clears_ibf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_idr_rd && !host_wr) |=> !loc_status[1]);

   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      recover_req |=> !recover_req);

   p_req_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      recover_req |-> !loc_status[4]);

   p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recover_req) |-> ($past(loc_idr_rd) && $past(loc_status[4])
                              && ($past(loc_idr_data) == CODE_W)));
endmodule

bind kcs_recovery_trigger kcs_rt_chk #(.DW(DW), .CODE(CODE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr      (host_wr),
   .host_addr    (host_addr),
   .loc_idr_rd   (loc_idr_rd),
   .loc_idr_data (loc_idr_data),
   .loc_status   (loc_status),
   .loc_irq      (loc_irq),
   .recover_req  (recover_req)
);

// File: tb/kcs_recovery_trigger_tb.sv
module kcs_recovery_trigger_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          host_norsp;
   logic          loc_sw_wr = 1'b0, loc_idr_rd = 1'b0, loc_odr_wr = 1'b0;
   logic [DW-1:0] loc_sw_wdata = '0, loc_odr_wdata = '0;
   logic [DW-1:0] loc_idr_data, loc_status;
   logic          loc_irq, recover_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   kcs_recovery_trigger u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_norsp(host_norsp),
      .loc_sw_wr(loc_sw_wr), .loc_sw_wdata(loc_sw_wdata),
      .loc_idr_rd(loc_idr_rd), .loc_idr_data(loc_idr_data),
      .loc_odr_wr(loc_odr_wr), .loc_odr_wdata(loc_odr_wdata),
      .loc_status(loc_status), .loc_irq(loc_irq), .recover_req(recover_req)
   );

   // kinds: 0 status, 1 input byte, 2 irq, 3 recover_req, 4 host_rdata, 5 norsp
   function automatic logic [7:0] pick(int kind);
      case (kind)
         0: return loc_status;
         1: return loc_idr_data;
         2: return {7'd0, loc_irq};
         3: return {7'd0, recover_req};
         4: return host_rdata;
         default: return {7'd0, host_norsp};
      endcase
   endfunction

   task automatic expect_item(int kind, logic [7:0] exp, string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   // inputs change 2 time units after an edge; monitor compares at edge+7
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      host_wr = 1'b0; host_rd = 1'b0; loc_sw_wr = 1'b0;
      loc_idr_rd = 1'b0; loc_odr_wr = 1'b0;
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #7;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            act = pick(it.kind);
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      // R9: host read while held in reset
      step();
      host_rd = 1'b1; host_addr = 1'b1;
      expect_item(5, 8'h01, "R9 norsp in reset");
      expect_item(4, 8'h00, "R9 rdata in reset");
      step();
      rst_n = 1'b1;
      step();
      expect_item(5, 8'h00, "R9 norsp out of reset");
      expect_item(0, 8'h00, "R1 status");
      expect_item(2, 8'h00, "R1 irq");
      expect_item(3, 8'h00, "R1 recover_req");
      host_rd = 1'b0;

      // R5: software mask
      step();
      loc_sw_wr = 1'b1; loc_sw_wdata = 8'hFF;
      step();
      idle();
      expect_item(0, 8'hF4, "R5 all-ones write");
      loc_sw_wr = 1'b1; loc_sw_wdata = 8'h10;
      step();
      idle();
      expect_item(0, 8'h10, "R5 ready only");

      // R2: host data write
      host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'h5A;
      step();
      idle();
      expect_item(0, 8'h12, "R2 status after data write");
      expect_item(2, 8'h01, "R2 irq");
      expect_item(1, 8'h5A, "R2 stored byte");
      host_rd = 1'b1; host_addr = 1'b1;
      expect_item(4, 8'h12, "R9 host status read");
      step();
      idle();

      // R4: consume clears IBF
      loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(0, 8'h10, "R4 ibf cleared");
      expect_item(2, 8'h00, "R4 irq low");

      // R7: non-code byte with Ready set
      host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'h45;
      step();
      idle();
      loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(3, 8'h00, "R7 other byte no request");
      expect_item(0, 8'h10, "R7 ready kept");

      // R3 + R6: code through command address
      host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h44;
      step();
      idle();
      expect_item(0, 8'h1A, "R3 status after command write");
      loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(3, 8'h01, "R6 request via command address");
      expect_item(0, 8'h08, "R6 ready cleared");
      step();
      expect_item(3, 8'h00, "R6 single-cycle pulse");

      // R7: code with Ready clear
      host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'h44;
      step();
      idle();
      expect_item(0, 8'h02, "R2 cd cleared by data write");
      loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(3, 8'h00, "R7 code without ready");
      expect_item(0, 8'h00, "R7 status after consume");

      // R4: write and consume in the same cycle
      host_wr = 1'b1; host_wdata = 8'h33;
      step();
      idle();
      host_wr = 1'b1; host_wdata = 8'h77; loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(0, 8'h02, "R4 write wins over consume");
      expect_item(1, 8'h77, "R4 new byte kept");
      loc_idr_rd = 1'b1;
      step();
      idle();

      // R6 via data address
      loc_sw_wr = 1'b1; loc_sw_wdata = 8'h10;
      host_wr = 1'b1; host_wdata = 8'h44;
      step();
      idle();
      expect_item(0, 8'h12, "R6 armed with code pending");
      loc_idr_rd = 1'b1;
      step();
      idle();
      expect_item(3, 8'h01, "R6 request via data address");
      expect_item(0, 8'h00, "R6 ready and ibf cleared");
      step();
      expect_item(3, 8'h00, "R6 pulse ends");

      // R10: recovery beats a concurrent Ready write
      loc_sw_wr = 1'b1; loc_sw_wdata = 8'h10;
      host_wr = 1'b1; host_wdata = 8'h44;
      step();
      idle();
      loc_idr_rd = 1'b1; loc_sw_wr = 1'b1; loc_sw_wdata = 8'h10;
      step();
      idle();
      expect_item(3, 8'h01, "R10 request fires");
      expect_item(0, 8'h00, "R10 ready ends clear");

      // R8: output byte
      loc_odr_wr = 1'b1; loc_odr_wdata = 8'hA5;
      step();
      idle();
      expect_item(0, 8'h01, "R8 obf set");
      host_rd = 1'b1; host_addr = 1'b0;
      expect_item(4, 8'hA5, "R8 host reads output byte");
      step();
      idle();
      expect_item(0, 8'h00, "R8 obf cleared by host read");

      step();
      step();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule